// File: doc/BRIEF.md
# Bit-Serial Gray Code Max/Min Sorter

This block compares two reflected binary Gray code words that arrive one bit pair per clock, most significant bit first. It emits the matching bit of the larger word and of the smaller word in the same cycle as each input pair, so that both sorted words stream out without first being converted to binary.

A two-bit comparison state records one of four conditions about the bits seen so far:

- the prefixes are equal and have even parity;
- the prefixes are equal and have odd parity;
- word g is known to be larger;
- word h is known to be larger.

Prefix parity matters because, in reflected Gray code, an odd number of ones above the first differing bit reverses which input at that bit is the larger value. A `start` pulse that comes with the first bit pair clears the state. `valid` qualifies each bit pair, and `done` marks the last bit of a word of `WORD_BITS` bits.

Top module: `gray_serial_sorter`

## Requirements
- R1: After reset the comparison state is "equal, even parity" (code 2'b00) and the bit counter is zero, so a valid pair with no `start` is handled as the first bit of a word in that state.
- R2: From state 2'b00 a valid pair moves the state to `{bit_g, bit_h}`: 00 stays in 00, 11 goes to 2'b11 (equal, odd), 10 goes to 2'b10 (g larger), and 01 goes to 2'b01 (h larger).
- R3: From state 2'b11 a valid pair moves the state to the bitwise inverse of `{bit_g, bit_h}`: 11 goes to 00, 00 stays in 11, 10 goes to 01, and 01 goes to 10.
- R4: States 2'b10 and 2'b01 keep their value for every later valid pair until `start` or reset.
- R5: Outputs are chosen from the state held before the current pair:
  - state 00: `max_bit` is g OR h and `min_bit` is g AND h;
  - state 11: `max_bit` is g AND h and `min_bit` is g OR h;
  - state 10: `max_bit` is g and `min_bit` is h;
  - state 01: `max_bit` is h and `min_bit` is g.

  When the two input bits are equal, both outputs carry that bit.
- R6: `start` makes the current cycle behave as state 00 and bit index 0, whatever the earlier state was. With `valid` low, `start` alone clears the state and the counter.
- R7: A cycle with `valid` low leaves the state and the bit counter unchanged, whatever values `bit_g` and `bit_h` carry.
- R8: `out_valid` equals `valid`. `done` is high exactly on the `WORD_BITS`-th valid pair counted from `start` or reset, and never when `valid` is low.
- R9: Over a full word, the serial `max_bit` and `min_bit` streams are the Gray codes of the larger and of the smaller decoded integer values of the two inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Marks the first bit pair of a new word |
| valid | input | 1 | Qualifies `bit_g` and `bit_h` this cycle |
| bit_g | input | 1 | Current bit of Gray word g, most significant bit first |
| bit_h | input | 1 | Current bit of Gray word h, most significant bit first |
| max_bit | output | 1 | Current bit of the larger word |
| min_bit | output | 1 | Current bit of the smaller word |
| out_valid | output | 1 | The output bits are meaningful this cycle |
| done | output | 1 | This is the last bit of the word |

## Verification
The bench sweeps every pair of 6-bit codewords. It checks the output streams against max and min values obtained by decoding both words to integers. A design that skipped the parity inversion would order pairs wrongly whenever the equal prefix contains an odd number of ones.

Directed sequences cover several corner cases:
- a `start` issued while the state is absorbing, which a design that honoured the stale state would answer with swapped bits;
- idle cycles that carry bits which would change the state, which a design that updates without `valid` would turn into wrong results;
- reads after the word is decided, where a non-absorbing state would start tracking later bits;
- the placement of `done` after idle gaps, where a counter that advances on idle cycles would flag the wrong bit.

// File: rtl/gss_pkg.sv
package gss_pkg;
   typedef enum logic [1:0] {
      CMP_EVEN  = 2'b00,
      CMP_HLEAD = 2'b01,
      CMP_GLEAD = 2'b10,
      CMP_ODD   = 2'b11
   } cmp_state_e;
endpackage

// File: rtl/gss_next.sv
module gss_next
   import gss_pkg::*;
(
   input  cmp_state_e cur,
   input  logic       bit_g,
   input  logic       bit_h,
   output cmp_state_e nxt
);
   always_comb begin
      unique case (cur)
         CMP_EVEN:  nxt = cmp_state_e'({bit_g, bit_h});
         CMP_ODD:   nxt = cmp_state_e'(~{bit_g, bit_h});
         CMP_GLEAD: nxt = CMP_GLEAD;
         default:   nxt = CMP_HLEAD;
      endcase
   end
endmodule

// File: rtl/gss_pick.sv
module gss_pick
   import gss_pkg::*;
(
   input  cmp_state_e cur,
   input  logic       bit_g,
   input  logic       bit_h,
   output logic       max_bit,
   output logic       min_bit
);
   logic any_one, both_one;

   assign any_one  = bit_g | bit_h;
   assign both_one = bit_g & bit_h;

   always_comb begin
      unique case (cur)
         CMP_EVEN:  begin max_bit = any_one;  min_bit = both_one; end
         CMP_ODD:   begin max_bit = both_one; min_bit = any_one;  end
         CMP_GLEAD: begin max_bit = bit_g;    min_bit = bit_h;    end
         default:   begin max_bit = bit_h;    min_bit = bit_g;    end
      endcase
   end
endmodule

// File: rtl/gss_bitctr.sv
module gss_bitctr #(
   parameter int WORD_BITS = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic valid,
   output logic last
);
   localparam int CW = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
   localparam logic [CW-1:0] LAST_IDX = CW'(WORD_BITS - 1);

   logic [CW-1:0] cnt_q, cnt_cur;

   assign cnt_cur = start ? '0 : cnt_q;
   assign last    = valid && (cnt_cur == LAST_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (valid)
         cnt_q <= last ? '0 : cnt_cur + CW'(1);
      else if (start)
         cnt_q <= '0;
   end
endmodule

// File: rtl/gray_serial_sorter.sv
module gray_serial_sorter
   import gss_pkg::*;
#(
   parameter int WORD_BITS = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic valid,
   input  logic bit_g,
   input  logic bit_h,
   output logic max_bit,
   output logic min_bit,
   output logic out_valid,
   output logic done
);
   generate
      if (WORD_BITS < 1) begin : g_bad_width
         $error("gray_serial_sorter: WORD_BITS must be at least 1");
      end
   endgenerate

   cmp_state_e st_q, st_cur, st_nxt;

   assign st_cur = start ? CMP_EVEN : st_q;

   gss_next u_next (
      .cur   (st_cur),
      .bit_g (bit_g),
      .bit_h (bit_h),
      .nxt   (st_nxt)
   );

   gss_pick u_pick (
      .cur     (st_cur),
      .bit_g   (bit_g),
      .bit_h   (bit_h),
      .max_bit (max_bit),
      .min_bit (min_bit)
   );

   gss_bitctr #(.WORD_BITS(WORD_BITS)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .valid (valid),
      .last  (done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         st_q <= CMP_EVEN;
      else if (valid)
         st_q <= st_nxt;
      else if (start)
         st_q <= CMP_EVEN;
   end

   assign out_valid = valid;
endmodule

// File: rtl/gss_checker.sv
module gss_checker #(
   parameter int WORD_BITS = 6
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       valid,
   input logic       bit_g,
   input logic       bit_h,
   input logic       max_bit,
   input logic       min_bit,
   input logic       out_valid,
   input logic       done,
   input logic [1:0] st
);
   // R2: an even-parity equal state, or a start, takes the input pair as the next state
   p_even_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      valid && (start || st == 2'b00) |=> st == {$past(bit_g), $past(bit_h)});

   // R3: the odd-parity equal state takes the inverted pair
   p_odd_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !start && st == 2'b11 |=> st == ~{$past(bit_g), $past(bit_h)});

   // R4: a decided order never changes
   p_absorb_r4: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !start && (st == 2'b01 || st == 2'b10) |=> st == $past(st));

   // R5: the two outputs are always the two input bits in some order
   p_perm_r5: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> ((max_bit == bit_g && min_bit == bit_h) ||
                 (max_bit == bit_h && min_bit == bit_g)));

   // R5: equal input bits are copied to both outputs
   p_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      valid && bit_g == bit_h |-> max_bit == bit_g && min_bit == bit_g);

   // R6: a start on its own clears the state
   p_start_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start && !valid |=> st == 2'b00);

   // R7: idle cycles leave the state untouched
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !valid && !start |=> $stable(st));

   // R8: output qualifier and done flag follow valid
   p_outvalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == valid && (done -> valid));

   // R8: with words longer than one bit, done is never asserted on two successive cycles
   p_done_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (WORD_BITS > 1) && done |=> !done);
endmodule

bind gray_serial_sorter gss_checker #(.WORD_BITS(WORD_BITS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .valid     (valid),
   .bit_g     (bit_g),
   .bit_h     (bit_h),
   .max_bit   (max_bit),
   .min_bit   (min_bit),
   .out_valid (out_valid),
   .done      (done),
   .st        (st_q)
);

// File: tb/tb_gray_serial_sorter.sv
module tb_gray_serial_sorter;
   localparam int W = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, valid = 1'b0, bit_g = 1'b0, bit_h = 1'b0;
   logic max_bit, min_bit, out_valid, done;
   int total = 0, bad = 0, cycles = 0;

   always #2 clk = ~clk;

   gray_serial_sorter #(.WORD_BITS(W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .valid(valid),
      .bit_g(bit_g), .bit_h(bit_h), .max_bit(max_bit), .min_bit(min_bit),
      .out_valid(out_valid), .done(done)
   );

   task automatic check(input string what, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b", what, act, exp);
      end
   endtask

   task automatic drive(input logic s, input logic v, input logic g, input logic h);
      @(negedge clk);
      start = s; valid = v; bit_g = g; bit_h = h;
      #1;
   endtask

   function automatic int gray_dec(input int gc);
      int b = 0;
      for (int i = W - 1; i >= 0; i--) begin
         int prev = (i == W - 1) ? 0 : ((b >> (i + 1)) & 1);
         b |= (prev ^ ((gc >> i) & 1)) << i;
      end
      return b;
   endfunction

   function automatic int gray_enc(input int v);
      return v ^ (v >> 1);
   endfunction

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 200000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<=200000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1: reset state behaves as equal/even: OR to max, AND to min
      drive(0, 1, 1, 0);
      check("R1 max after reset", max_bit, 1'b1);
      check("R1 min after reset", min_bit, 1'b0);
      check("R8 out_valid high", out_valid, 1'b1);

      // R2: even state with 00 stays even; then 10 leads to g larger
      drive(1, 1, 0, 0);
      drive(0, 1, 1, 0);
      check("R2 even state max=OR", max_bit, 1'b1);
      drive(0, 1, 0, 1);
      check("R2 g lead max=g", max_bit, 1'b0);
      check("R2 g lead min=h", min_bit, 1'b1);
      // R4: stays g-larger for later pairs
      drive(0, 1, 0, 1);
      check("R4 absorbing g lead max", max_bit, 1'b0);
      drive(0, 1, 1, 0);
      check("R4 absorbing g lead min", min_bit, 1'b0);

      // R3: 11 moves to odd state, where max=AND min=OR; then 10 gives h larger
      drive(1, 1, 1, 1);
      drive(0, 1, 1, 0);
      check("R3 odd state max=AND", max_bit, 1'b0);
      check("R3 odd state min=OR", min_bit, 1'b1);
      drive(0, 1, 1, 0);
      check("R5 h lead max=h", max_bit, 1'b0);
      check("R5 h lead min=g", min_bit, 1'b1);

      // R6: start while in h-larger state acts as even state this cycle
      drive(1, 1, 1, 0);
      check("R6 start override max", max_bit, 1'b1);
      check("R6 start override min", min_bit, 1'b0);

      // R7: idle cycle with bits that would change state; g still larger
      drive(0, 0, 1, 1);
      check("R8 out_valid low when idle", out_valid, 1'b0);
      check("R8 no done when idle", done, 1'b0);
      drive(0, 1, 0, 1);
      check("R7 state kept over idle max", max_bit, 1'b0);
      check("R7 state kept over idle min", min_bit, 1'b1);

      // R6: start alone clears state; next valid pair behaves as even
      drive(1, 0, 0, 0);
      drive(0, 1, 0, 1);
      check("R6 lone start clears max", max_bit, 1'b1);
      check("R6 lone start clears min", min_bit, 1'b0);
      drive(0, 0, 0, 0);

      // R9 and R8: exhaustive sweep against decoded integer order
      for (int a = 0; a < (1 << W); a++) begin
         for (int b = 0; b < (1 << W); b++) begin
            int ga = gray_enc(a);
            int gb = gray_enc(b);
            int da = gray_dec(ga);
            int db = gray_dec(gb);
            int mx = gray_enc((da > db) ? da : db);
            int mn = gray_enc((da > db) ? db : da);
            for (int k = W - 1; k >= 0; k--) begin
               if (((a + b) % 7 == 3) && k == 2) begin
                  drive(0, 0, ~ga[k], gb[k]);
                  check("R8 idle out_valid in word", out_valid, 1'b0);
                  check("R8 idle done in word", done, 1'b0);
               end
               drive(k == W - 1, 1, ga[k], gb[k]);
               check($sformatf("R9 max bit %0d of %0d,%0d", k, a, b), max_bit, mx[k]);
               check($sformatf("R9 min bit %0d of %0d,%0d", k, a, b), min_bit, mn[k]);
               check($sformatf("R8 done bit %0d", k), done, k == 0);
            end
         end
      end

      drive(0, 0, 0, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule